// File: doc/BRIEF.md
# Codec Serial Frame Port Controller

This block is the master end of a synchronous serial link to an audio and telecom codec. While enabled it runs an endless train of frames. Each frame is 128 bit-clock periods long, and frames follow each other with no gap. One system clock cycle equals one bit period. The `sclk_en_o` output gates the external bit clock.

The first 64 periods of a frame carry a 64-bit payload, sent MSB first on `tx_o`. During the same 64 periods the block collects a 64-bit reply from `rx_i` into the same shifter. The last 64 periods are silent. `fsync_o` marks the final period of each frame. At the end of that period the outgoing word is built from three one-entry holding stages:
- the audio sample,
- the telecom sample,
- an optional codec register access.

Each of these stages accepts data through a valid/ready handshake. A field with nothing new repeats the value it carried in the previous frame. The audio and telecom valid flags show which fields are new.

When the payload ends, the reply is split into fields. Received samples flagged valid come out with one-cycle strobes. Read data is strobed when the frame carried a new read request.

The sequencer has three named states:
- `ST_IDLE`: stopped.
- `ST_PAYLOAD`: clocks 1–64.
- `ST_QUIET`: clocks 65–128.

It has these transitions:
- IDLE→QUIET on enable. The counter is preset to the last clock, so a sync period follows at once.
- QUIET→PAYLOAD at the end of clock 128 while enabled.
- QUIET→IDLE at the end of clock 128 when disabled.
- PAYLOAD→QUIET after clock 64.

Top module: `codec_frame_port`

## Requirements
- R1: While enabled, `fsync_o` pulses once every 128 cycles with no gap between frames. After `enable_i` is sampled high in the stopped state, the first pulse appears in the next cycle.
- R2: `fsync_o` is high for exactly one cycle, the 128th of the frame. The payload starts in the following cycle.
- R3: The transmit word layout is:
  - [63:48] audio sample
  - [47] 0
  - [46:43] register address
  - [42] direction (1 write, 0 read)
  - [41:34] 0
  - [33] audio-valid
  - [32] telecom-valid
  - [31:16] telecom sample
  - [15:0] register write data
- R4: The word is sent on `tx_o` MSB first, one bit per cycle, in the 64 cycles that follow the `fsync_o` cycle.
- R5: The audio-valid and telecom-valid flags are 1 only in the frame that carries a newly accepted sample of that kind.
- R6: A field with no new data repeats the value sent in that field in the previous frame.
- R7: `tx_o` is low in every cycle outside the 64 payload cycles.
- R8: `rx_i` is sampled on the falling clock edge and uses the same layout as the transmit word. In the cycle after the last payload bit, `rx_aud_stb_o` or `rx_tel_stb_o` pulses with the received sample only when the received bit 33 or bit 32, respectively, is set.
- R9: `rd_stb_o` pulses with received bits [15:0] only for a frame that carried a newly accepted read request (direction 0). It does not pulse for write requests or repeated fields.
- R10: A sample accepted in the `fsync_o` cycle is not in the frame that starts next. It is sent, flagged valid, in the frame after that.
- R11: When `enable_i` is low at the end of a frame, no `fsync_o` pulse is given and no new frame starts. `sclk_en_o`, `fsync_o` and `tx_o` then stay low until re-enabled.
- R12: Each input port holds one entry. Its ready is low from acceptance until the entry is loaded into a frame.
- R13: After reset, the block is stopped, the outputs are low and all three readies are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, one bit period per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Run frames while high |
| aud_valid_i | input | 1 | Audio sample offered |
| aud_ready_o | output | 1 | Audio holding stage empty |
| aud_data_i | input | 16 | Audio sample to send |
| tel_valid_i | input | 1 | Telecom sample offered |
| tel_ready_o | output | 1 | Telecom holding stage empty |
| tel_data_i | input | 16 | Telecom sample to send |
| reg_valid_i | input | 1 | Register access offered |
| reg_ready_o | output | 1 | Register holding stage empty |
| reg_write_i | input | 1 | 1 write, 0 read |
| reg_addr_i | input | 4 | Codec register address |
| reg_wdata_i | input | 16 | Register write data |
| sclk_en_o | output | 1 | Bit clock gate, high while frames run |
| fsync_o | output | 1 | Frame sync pulse |
| tx_o | output | 1 | Serial data out |
| rx_i | input | 1 | Serial data in |
| rx_aud_stb_o | output | 1 | Received audio sample strobe |
| rx_aud_data_o | output | 16 | Received audio sample |
| rx_tel_stb_o | output | 1 | Received telecom sample strobe |
| rx_tel_data_o | output | 16 | Received telecom sample |
| rd_stb_o | output | 1 | Register read data strobe |
| rd_data_o | output | 16 | Register read data |

## Verification
Two events can land in the same cycle:
- a handshake on a holding stage;
- the word load at the sync period, which samples and empties that stage.

The bench offers an audio sample in exactly the cycle where `fsync_o` is high. It then checks two things:
- the frame that starts next repeats the old audio value with audio-valid 0;
- the frame after that carries the new value with the flag set.

A lost or duplicated sample would show up as a wrong field or flag in one of those two frames.

// File: rtl/cfp_pkg.sv
package cfp_pkg;
    localparam int WORD_W   = 64;
    localparam int SAMPLE_W = 16;
    localparam int ADDR_W   = 4;

    localparam int AUD_MSB  = 63;
    localparam int ADDR_MSB = 46;
    localparam int RW_BIT   = 42;
    localparam int AV_BIT   = 33;
    localparam int TV_BIT   = 32;
    localparam int TEL_MSB  = 31;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_PAYLOAD = 2'd1,
        ST_QUIET   = 2'd2
    } cfp_state_e;

    function automatic logic [WORD_W-1:0] pack_word(
        input logic [SAMPLE_W-1:0] aud,
        input logic [ADDR_W-1:0]   addr,
        input logic                wr,
        input logic                av,
        input logic                tv,
        input logic [SAMPLE_W-1:0] tel,
        input logic [SAMPLE_W-1:0] wdata
    );
        return {aud, 1'b0, addr, wr, 8'h00, av, tv, tel, wdata};
    endfunction
endpackage

// File: rtl/cfp_sequencer.sv
module cfp_sequencer
    import cfp_pkg::*;
#(
    parameter int FRAME_LEN = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable_i,
    output logic load_o,
    output logic shift_o,
    output logic last_o,
    output logic sclk_en_o
);
    localparam int HALF = FRAME_LEN / 2;
    localparam int CW   = $clog2(FRAME_LEN);
    localparam logic [CW-1:0] LAST_CNT  = CW'(FRAME_LEN - 1);
    localparam logic [CW-1:0] HALF_LAST = CW'(HALF - 1);
    localparam logic [CW-1:0] HALF_CNT  = CW'(HALF);

    cfp_state_e state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                cnt_d = '0;
                if (enable_i) begin
                    state_d = ST_QUIET;
                    cnt_d   = LAST_CNT;
                end
            end
            ST_PAYLOAD: begin
                if (cnt_q == HALF_LAST) begin
                    state_d = ST_QUIET;
                    cnt_d   = HALF_CNT;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_QUIET: begin
                if (cnt_q == LAST_CNT) begin
                    cnt_d   = '0;
                    state_d = enable_i ? ST_PAYLOAD : ST_IDLE;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        load_o    = (state_q == ST_QUIET) && (cnt_q == LAST_CNT) && enable_i;
        shift_o   = (state_q == ST_PAYLOAD);
        last_o    = (state_q == ST_PAYLOAD) && (cnt_q == HALF_LAST);
        sclk_en_o = (state_q != ST_IDLE);
    end

    a_r2_sync_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |=> !load_o && shift_o);

    a_r11_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
        !sclk_en_o |-> !load_o && !shift_o);
endmodule

// File: rtl/cfp_tx_staging.sv
module cfp_tx_staging
    import cfp_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  logic                aud_valid_i,
    output logic                aud_ready_o,
    input  logic [SAMPLE_W-1:0] aud_data_i,
    input  logic                tel_valid_i,
    output logic                tel_ready_o,
    input  logic [SAMPLE_W-1:0] tel_data_i,
    input  logic                reg_valid_i,
    output logic                reg_ready_o,
    input  logic                reg_write_i,
    input  logic [ADDR_W-1:0]   reg_addr_i,
    input  logic [SAMPLE_W-1:0] reg_wdata_i,
    output logic [WORD_W-1:0]   word_o,
    output logic                rd_frame_o
);
    logic                aud_pend_q, tel_pend_q, reg_pend_q;
    logic [SAMPLE_W-1:0] aud_hold_q, tel_hold_q, wd_hold_q;
    logic [ADDR_W-1:0]   addr_hold_q;
    logic                wr_hold_q;
    logic [SAMPLE_W-1:0] aud_last_q, tel_last_q, wd_last_q;
    logic [ADDR_W-1:0]   addr_last_q;
    logic                wr_last_q;

    assign aud_ready_o = !aud_pend_q;
    assign tel_ready_o = !tel_pend_q;
    assign reg_ready_o = !reg_pend_q;

    always_comb begin
        word_o = pack_word(
            aud_pend_q ? aud_hold_q  : aud_last_q,
            reg_pend_q ? addr_hold_q : addr_last_q,
            reg_pend_q ? wr_hold_q   : wr_last_q,
            aud_pend_q, tel_pend_q,
            tel_pend_q ? tel_hold_q  : tel_last_q,
            reg_pend_q ? wd_hold_q   : wd_last_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            aud_pend_q  <= 1'b0;
            tel_pend_q  <= 1'b0;
            reg_pend_q  <= 1'b0;
            aud_hold_q  <= '0;
            tel_hold_q  <= '0;
            wd_hold_q   <= '0;
            addr_hold_q <= '0;
            wr_hold_q   <= 1'b0;
            aud_last_q  <= '0;
            tel_last_q  <= '0;
            wd_last_q   <= '0;
            addr_last_q <= '0;
            wr_last_q   <= 1'b0;
            rd_frame_o  <= 1'b0;
        end else begin
            if (load_i) begin
                rd_frame_o <= reg_pend_q && !wr_hold_q;
                if (aud_pend_q) begin
                    aud_last_q <= aud_hold_q;
                    aud_pend_q <= 1'b0;
                end
                if (tel_pend_q) begin
                    tel_last_q <= tel_hold_q;
                    tel_pend_q <= 1'b0;
                end
                if (reg_pend_q) begin
                    addr_last_q <= addr_hold_q;
                    wr_last_q   <= wr_hold_q;
                    wd_last_q   <= wd_hold_q;
                    reg_pend_q  <= 1'b0;
                end
            end
            if (aud_valid_i && aud_ready_o) begin
                aud_hold_q <= aud_data_i;
                aud_pend_q <= 1'b1;
            end
            if (tel_valid_i && tel_ready_o) begin
                tel_hold_q <= tel_data_i;
                tel_pend_q <= 1'b1;
            end
            if (reg_valid_i && reg_ready_o) begin
                addr_hold_q <= reg_addr_i;
                wr_hold_q   <= reg_write_i;
                wd_hold_q   <= reg_wdata_i;
                reg_pend_q  <= 1'b1;
            end
        end
    end

    a_r12_aud_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (aud_valid_i && aud_ready_o) |=> !aud_ready_o);

    a_r12_reg_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_valid_i && reg_ready_o) |=> !reg_ready_o);
endmodule

// File: rtl/cfp_shifter.sv
module cfp_shifter
    import cfp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              shift_i,
    input  logic              last_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              rx_i,
    output logic              tx_bit_o,
    output logic [WORD_W-1:0] rx_word_o,
    output logic              done_o
);
    logic [WORD_W-1:0] shreg_q;
    logic              rx_fall_q;

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) rx_fall_q <= 1'b0;
        else        rx_fall_q <= rx_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q   <= '0;
            rx_word_o <= '0;
            done_o    <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (load_i) begin
                shreg_q <= word_i;
            end else if (shift_i) begin
                shreg_q <= {shreg_q[WORD_W-2:0], rx_fall_q};
                if (last_i) begin
                    rx_word_o <= {shreg_q[WORD_W-2:0], rx_fall_q};
                    done_o    <= 1'b1;
                end
            end
        end
    end

    assign tx_bit_o = shift_i ? shreg_q[WORD_W-1] : 1'b0;

    a_r8_done_follows_shift: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(shift_i) && !shift_i);
endmodule

// File: rtl/codec_frame_port.sv
module codec_frame_port
    import cfp_pkg::*;
#(
    parameter int FRAME_LEN = 128
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        enable_i,
    input  logic        aud_valid_i,
    output logic        aud_ready_o,
    input  logic [15:0] aud_data_i,
    input  logic        tel_valid_i,
    output logic        tel_ready_o,
    input  logic [15:0] tel_data_i,
    input  logic        reg_valid_i,
    output logic        reg_ready_o,
    input  logic        reg_write_i,
    input  logic [3:0]  reg_addr_i,
    input  logic [15:0] reg_wdata_i,
    output logic        sclk_en_o,
    output logic        fsync_o,
    output logic        tx_o,
    input  logic        rx_i,
    output logic        rx_aud_stb_o,
    output logic [15:0] rx_aud_data_o,
    output logic        rx_tel_stb_o,
    output logic [15:0] rx_tel_data_o,
    output logic        rd_stb_o,
    output logic [15:0] rd_data_o
);
    localparam int GW = $clog2(FRAME_LEN) + 1;

    logic              load, shift, last, rd_frame, done;
    logic [WORD_W-1:0] tx_word, rx_word;

    cfp_sequencer #(.FRAME_LEN(FRAME_LEN)) u_seq (
        .clk(clk), .rst_n(rst_n), .enable_i(enable_i),
        .load_o(load), .shift_o(shift), .last_o(last), .sclk_en_o(sclk_en_o)
    );

    cfp_tx_staging u_stage (
        .clk(clk), .rst_n(rst_n), .load_i(load),
        .aud_valid_i(aud_valid_i), .aud_ready_o(aud_ready_o), .aud_data_i(aud_data_i),
        .tel_valid_i(tel_valid_i), .tel_ready_o(tel_ready_o), .tel_data_i(tel_data_i),
        .reg_valid_i(reg_valid_i), .reg_ready_o(reg_ready_o), .reg_write_i(reg_write_i),
        .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
        .word_o(tx_word), .rd_frame_o(rd_frame)
    );

    cfp_shifter u_shift (
        .clk(clk), .rst_n(rst_n), .load_i(load), .shift_i(shift), .last_i(last),
        .word_i(tx_word), .rx_i(rx_i), .tx_bit_o(tx_o),
        .rx_word_o(rx_word), .done_o(done)
    );

    assign fsync_o       = load;
    assign rx_aud_stb_o  = done && rx_word[AV_BIT];
    assign rx_tel_stb_o  = done && rx_word[TV_BIT];
    assign rd_stb_o      = done && rd_frame;
    assign rx_aud_data_o = rx_word[AUD_MSB -: SAMPLE_W];
    assign rx_tel_data_o = rx_word[TEL_MSB -: SAMPLE_W];
    assign rd_data_o     = rx_word[SAMPLE_W-1:0];

    logic [GW-1:0] gap_q;
    logic          seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (!sclk_en_o) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (fsync_o) begin
            gap_q  <= '0;
            seen_q <= 1'b1;
        end else begin
            gap_q <= gap_q + 1'b1;
        end
    end

    a_r1_frame_period: assert property (@(posedge clk) disable iff (!rst_n)
        (fsync_o && seen_q) |-> (gap_q == GW'(FRAME_LEN - 1)));

    a_r7_tx_low_at_sync: assert property (@(posedge clk) disable iff (!rst_n)
        fsync_o |-> !tx_o);
endmodule

// File: tb/codec_frame_port_tb.sv
module codec_frame_port_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable_i = 1'b0;
    logic        aud_valid_i = 1'b0, tel_valid_i = 1'b0, reg_valid_i = 1'b0;
    logic [15:0] aud_data_i = '0, tel_data_i = '0, reg_wdata_i = '0;
    logic        reg_write_i = 1'b0;
    logic [3:0]  reg_addr_i = '0;
    logic        rx_i = 1'b0;
    logic        aud_ready_o, tel_ready_o, reg_ready_o, sclk_en_o, fsync_o, tx_o;
    logic        rx_aud_stb_o, rx_tel_stb_o, rd_stb_o;
    logic [15:0] rx_aud_data_o, rx_tel_data_o, rd_data_o;

    int tests = 0, fails = 0;

    always #2.5 clk = ~clk;

    codec_frame_port u_dut (
        .clk(clk), .rst_n(rst_n), .enable_i(enable_i),
        .aud_valid_i(aud_valid_i), .aud_ready_o(aud_ready_o), .aud_data_i(aud_data_i),
        .tel_valid_i(tel_valid_i), .tel_ready_o(tel_ready_o), .tel_data_i(tel_data_i),
        .reg_valid_i(reg_valid_i), .reg_ready_o(reg_ready_o), .reg_write_i(reg_write_i),
        .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
        .sclk_en_o(sclk_en_o), .fsync_o(fsync_o), .tx_o(tx_o), .rx_i(rx_i),
        .rx_aud_stb_o(rx_aud_stb_o), .rx_aud_data_o(rx_aud_data_o),
        .rx_tel_stb_o(rx_tel_stb_o), .rx_tel_data_o(rx_tel_data_o),
        .rd_stb_o(rd_stb_o), .rd_data_o(rd_data_o)
    );

    // codec model: slot < 64 means a payload bit is in flight
    int          slot = 64;
    int          frames = 0;
    int          quiet_hi = 0;
    logic [63:0] tx_cap = '0, tx_last = '0;
    logic [63:0] rx_word = '0;
    logic        got_aud = 0, got_tel = 0, got_rd = 0;
    logic [15:0] v_aud = '0, v_tel = '0, v_rd = '0;

    always @(posedge clk) begin
        #1 rx_i = (slot < 64) ? rx_word[63-slot] : 1'b0;
    end

    always @(negedge clk) begin
        if (slot < 64) begin
            tx_cap[63-slot] = tx_o;
            slot = slot + 1;
            if (slot == 64) begin
                tx_last = tx_cap;
                frames  = frames + 1;
            end
        end else begin
            if (tx_o) quiet_hi = quiet_hi + 1;
        end
        if (fsync_o) slot = 0;
        if (rx_aud_stb_o) begin got_aud = 1; v_aud = rx_aud_data_o; end
        if (rx_tel_stb_o) begin got_tel = 1; v_tel = rx_tel_data_o; end
        if (rd_stb_o)     begin got_rd  = 1; v_rd  = rd_data_o;     end
    end

    initial begin
        #(5ns * 150000);
        fails = fails + 1;
        $display("FAIL watchdog: run did not finish (actual hung, expected done)");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests = tests + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] mk(input logic [15:0] a, input logic [3:0] ad,
        input logic w, input logic av, input logic tv, input logic [15:0] t, input logic [15:0] d);
        return {a, 1'b0, ad, w, 8'h00, av, tv, t, d};
    endfunction

    task automatic wait_frame();
        int f0 = frames;
        while (frames == f0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic clear_rx_flags();
        got_aud = 0; got_tel = 0; got_rd = 0;
    endtask

    task automatic push_aud(input logic [15:0] v);
        aud_valid_i = 1; aud_data_i = v;
        @(negedge clk);
        aud_valid_i = 0;
    endtask

    task automatic push_tel(input logic [15:0] v);
        tel_valid_i = 1; tel_data_i = v;
        @(negedge clk);
        tel_valid_i = 0;
    endtask

    task automatic push_reg(input logic w, input logic [3:0] a, input logic [15:0] d);
        reg_valid_i = 1; reg_write_i = w; reg_addr_i = a; reg_wdata_i = d;
        @(negedge clk);
        reg_valid_i = 0;
    endtask

    task automatic t_reset();
        check("R13 sclk_en", 64'(sclk_en_o), 0);
        check("R13 fsync", 64'(fsync_o), 0);
        check("R13 tx", 64'(tx_o), 0);
        check("R13 readies", 64'({aud_ready_o, tel_ready_o, reg_ready_o}), 64'h7);
    endtask

    task automatic t_start_and_period();
        int n = 0;
        enable_i = 1;
        @(negedge clk);
        check("R1 first sync next cycle", 64'(fsync_o), 1);
        @(negedge clk);
        check("R2 sync one cycle", 64'(fsync_o), 0);
        n = 1;
        while (!fsync_o && n < 400) begin @(negedge clk); n++; end
        check("R1 frame period", 64'(n), 128);
    endtask

    task automatic t_fields_and_flags();
        wait_frame();
        push_aud(16'hA5C3);
        check("R12 aud ready low while held", 64'(aud_ready_o), 0);
        push_tel(16'h1234);
        push_reg(1'b1, 4'hB, 16'hBEEF);
        check("R12 reg ready low while held", 64'(reg_ready_o), 0);
        wait_frame();
        check("R3 R4 R5 word with new fields", tx_last,
              mk(16'hA5C3, 4'hB, 1'b1, 1'b1, 1'b1, 16'h1234, 16'hBEEF));
        check("R12 readies back high", 64'({aud_ready_o, tel_ready_o, reg_ready_o}), 64'h7);
        push_tel(16'h0F0F);
        wait_frame();
        check("R6 R5 audio repeated, telecom new", tx_last,
              mk(16'hA5C3, 4'hB, 1'b1, 1'b0, 1'b1, 16'h0F0F, 16'hBEEF));
        wait_frame();
        check("R6 all repeated flags clear", tx_last,
              mk(16'hA5C3, 4'hB, 1'b1, 1'b0, 1'b0, 16'h0F0F, 16'hBEEF));
        check("R7 tx low outside payload", 64'(quiet_hi), 0);
    endtask

    task automatic t_receive();
        rx_word = mk(16'h6789, 4'h0, 1'b0, 1'b1, 1'b0, 16'h4321, 16'h5555);
        clear_rx_flags();
        wait_frame();
        check("R8 aud strobe", 64'(got_aud), 1);
        check("R8 aud data", 64'(v_aud), 64'h6789);
        check("R8 tel no strobe when flag clear", 64'(got_tel), 0);
        check("R9 no read strobe without request", 64'(got_rd), 0);
        rx_word = mk(16'h0000, 4'h0, 1'b0, 1'b0, 1'b1, 16'hCAFE, 16'hD00D);
        clear_rx_flags();
        wait_frame();
        check("R8 tel strobe", 64'(got_tel), 1);
        check("R8 tel data", 64'(v_tel), 64'hCAFE);
        check("R8 aud no strobe", 64'(got_aud), 0);
    endtask

    task automatic t_read();
        push_reg(1'b0, 4'h5, 16'h0000);
        rx_word = mk(16'h0000, 4'h5, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h9A9A);
        clear_rx_flags();
        wait_frame();
        check("R9 read request word", tx_last,
              mk(16'hA5C3, 4'h5, 1'b0, 1'b0, 1'b0, 16'h0F0F, 16'h0000));
        check("R9 read strobe", 64'(got_rd), 1);
        check("R9 read data", 64'(v_rd), 64'h9A9A);
        clear_rx_flags();
        wait_frame();
        check("R9 repeated read gives no strobe", 64'(got_rd), 0);
    endtask

    task automatic t_collide();
        int n = 0;
        while (!fsync_o && n < 400) begin @(negedge clk); n++; end
        push_aud(16'h7E7E);
        wait_frame();
        check("R10 sample in sync cycle deferred", tx_last[63:32],
              64'({16'hA5C3, 1'b0, 4'h5, 1'b0, 8'h00, 1'b0, 1'b0}));
        wait_frame();
        check("R10 deferred sample sent next", tx_last[63:32],
              64'({16'h7E7E, 1'b0, 4'h5, 1'b0, 8'h00, 1'b1, 1'b0}));
    endtask

    task automatic t_disable();
        int syncs = 0;
        int n = 0;
        repeat (10) @(negedge clk);
        enable_i = 0;
        repeat (300) begin
            @(negedge clk);
            if (fsync_o) syncs++;
        end
        check("R11 no sync after disable", 64'(syncs), 0);
        check("R11 clock gate off", 64'(sclk_en_o), 0);
        check("R11 tx low", 64'(tx_o), 0);
        enable_i = 1;
        @(negedge clk);
        n = 1;
        while (!fsync_o && n < 400) begin @(negedge clk); n++; end
        check("R11 R1 restart sync after one cycle", 64'(n), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_start_and_period();
        t_fields_and_flags();
        t_receive();
        t_read();
        t_collide();
        t_disable();
        check("R7 tx low outside payload overall", 64'(quiet_hi), 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule